// File: doc/BRIEF.md
# Interval and Watchdog Timer

This block is a down-counting timer clocked from the oscillator through a selectable prescaler. The prescaler produces one counter step every 768 × 2^n oscillator cycles, where n is a 3-bit select field. Software programs the block through a small write/read register port. That port holds a control register, an 8-bit reload register, a feed register and a read-only view of the live count.

In timer mode the block is a plain interval timer. Software starts and stops it with a run bit. Each underflow raises a timeout flag and reloads the count. In watchdog mode the counter runs whatever the run bit says. An underflow then raises the flag and emits a one-cycle system reset pulse. Software avoids that pulse by feeding the block: it writes 8'hA5 and then 8'h5A to the feed register as two consecutive writes. Watchdog mode keeps a power-down-inhibit output high. A request to leave watchdog mode takes effect only when a completed feed follows it. The active-low external reset returns every register to its reset value.

Top module: `wdt_core`

## Requirements
- R1: Counter steps arrive every 768 << sel oscillator cycles. The first underflow shows on the flag or the reset output exactly (reload + 1) × (768 << sel) cycles after the control or feed write that restarted the prescaler.
- R2: The control register (address 0) holds the prescale select in bits 7:5, run in bit 2, the timeout flag in bit 1 and the mode in bit 0. Bits 4:3 read 0. The reload register is at address 1, the feed register at address 2 (reads 0) and the live count at address 3, read-only.
- R3: In timer mode, run = 0 freezes the prescaler and the counter, so the count read back does not change.
- R4: A timer-mode underflow sets the flag and reloads the count from the reload register. No system reset pulse is produced.
- R5: Writing 0 to the flag bit clears it. Writing 1 to the flag bit leaves it unchanged.
- R6: A watchdog-mode underflow sets the flag and drives sys_rst_o high for exactly one cycle, even when run = 0.
- R7: pd_inhibit_o is high exactly while the mode bit reads 1.
- R8: Writing mode = 1 enters watchdog mode at once. While in watchdog mode, writing mode = 0 leaves the mode bit at 1 until a completed feed follows.
- R9: A feed completes only when 8'hA5 and then 8'h5A are written to address 2 in consecutive writes. Any other write in between aborts it. A completed feed loads the count from the reload register and restarts the prescaler.
- R10: Every write to the control register restarts the prescaler count from zero.
- R11: While rst_n is low, the control register reads 8'h00, the reload register and the count read 8'hFF, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 reload, 2 feed) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 reload, 2 feed, 3 count) |
| rd_data | output | 8 | Combinational read data |
| sys_rst_o | output | 1 | One-cycle system reset pulse on watchdog underflow |
| pd_inhibit_o | output | 1 | High while watchdog mode blocks power-down |

## Verification
The period is measured over a spread of prescale selects and reload values, in both modes. Products that come out equal by different routes (reload 3 at select 0, reload 1 at select 1, reload 0 at select 2) separate a wrong shift from a wrong reload count. Watchdog runs start with run = 0, so a design that gates the watchdog with the run bit never fires. Feed sequences are tried both complete and broken by an intervening write. A control rewrite partway through a prescaler interval shows whether the prescaler restarts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int CNT_W  = DATA_W;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_FEED   = 2'd2,
    REG_COUNT  = 2'd3
  } wdt_addr_e;

  localparam logic [DATA_W-1:0] FEED_KEY_A = 8'hA5;
  localparam logic [DATA_W-1:0] FEED_KEY_B = 8'h5A;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_DIV = 768,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
  localparam int PRE_W   = $clog2(MAX_DIV + 1);

  logic [PRE_W-1:0] pre_q, pre_d, last;

  always_comb begin
    last = (PRE_W'(BASE_DIV) << sel) - PRE_W'(1);
    tick = en && !clr && (pre_q == last);
    if (clr)       pre_d = '0;
    else if (tick) pre_d = '0;
    else if (en)   pre_d = pre_q + PRE_W'(1);
    else           pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              feed_done
);
  logic armed_q, armed_d;
  logic to_feed;

  always_comb begin
    to_feed   = wr_en && (wr_addr == REG_FEED);
    feed_done = to_feed && armed_q && (wr_data == FEED_KEY_B);
    armed_d   = armed_q;
    if (wr_en) armed_d = to_feed && (wr_data == FEED_KEY_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             run_in,
  input  logic             flag_in,
  input  logic             mode_in,
  input  logic             feed_done,
  input  logic             underflow,
  output logic [SEL_W-1:0] sel_q,
  output logic             run_q,
  output logic             flag_q,
  output logic             mode_q
);
  logic [SEL_W-1:0] sel_d;
  logic run_d, flag_d, mode_d, exit_q, exit_d;

  always_comb begin
    sel_d  = sel_q;
    run_d  = run_q;
    flag_d = flag_q;
    mode_d = mode_q;
    exit_d = exit_q;
    if (ctrl_wr) begin
      sel_d = sel_in;
      run_d = run_in;
      if (!flag_in) flag_d = 1'b0;
      if (mode_in) begin
        mode_d = 1'b1;
        exit_d = 1'b0;
      end else if (mode_q) begin
        exit_d = 1'b1;
      end
    end
    if (feed_done && exit_q) begin
      mode_d = 1'b0;
      exit_d = 1'b0;
    end
    if (underflow) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      mode_q <= 1'b0;
      exit_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      mode_q <= mode_d;
      exit_q <= exit_d;
    end
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             underflow
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    underflow = tick && !load && (cnt_q == '0);
    if (load || underflow) cnt_d = reload;
    else if (tick)         cnt_d = cnt_q - CNT_W'(1);
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int BASE_DIV = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_o,
  output logic              pd_inhibit_o
);
  logic             ctrl_wr, rel_wr, feed_done, tick, underflow, count_en;
  logic [SEL_W-1:0] sel_q;
  logic             run_q, flag_q, mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] reload_q, reload_d;
  logic             sys_rst_d;

  always_comb begin
    ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
    rel_wr    = wr_en && (wr_addr == REG_RELOAD);
    count_en  = mode_q || run_q;
    reload_d  = rel_wr ? wr_data : reload_q;
    sys_rst_d = underflow && mode_q;
  end

  wdt_feed_seq feed_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .feed_done(feed_done)
  );

  wdt_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .sel_in(wr_data[7:5]), .run_in(wr_data[2]), .flag_in(wr_data[1]),
    .mode_in(wr_data[0]), .feed_done(feed_done), .underflow(underflow),
    .sel_q(sel_q), .run_q(run_q), .flag_q(flag_q), .mode_q(mode_q)
  );

  wdt_prescaler #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .en(count_en), .clr(ctrl_wr || feed_done),
    .sel(sel_q), .tick(tick)
  );

  wdt_downcount #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(feed_done),
    .reload(reload_q), .cnt_q(cnt_q), .underflow(underflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q  <= '1;
      sys_rst_o <= 1'b0;
    end else begin
      reload_q  <= reload_d;
      sys_rst_o <= sys_rst_d;
    end
  end

  assign pd_inhibit_o = mode_q;

  always_comb begin
    case (rd_addr)
      REG_CTRL:   rd_data = {sel_q, 2'b00, run_q, flag_q, mode_q};
      REG_RELOAD: rd_data = reload_q;
      REG_COUNT:  rd_data = DATA_W'(cnt_q);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             feed_done,
  input logic             mode_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             sys_rst_o,
  input logic             pd_inhibit_o
);
  // R6
  sys_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);

  // R7
  sys_rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> $past(pd_inhibit_o));

  // R8
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q) |-> $past(feed_done));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));

  // R3
  count_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $past(tick || feed_done));
endmodule

bind wdt_core wdt_core_chk #(.CNT_W(wdt_pkg::CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .feed_done(feed_done),
  .mode_q(mode_q), .flag_q(flag_q), .cnt_q(cnt_q),
  .sys_rst_o(sys_rst_o), .pd_inhibit_o(pd_inhibit_o)
);

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;
  import wdt_pkg::*;

  logic       clk, rst_n, wr_en, sys_rst_o, pd_inhibit_o;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  int vec_cnt = 0;
  int err_cnt = 0;
  logic [7:0] rv;

  // vector: [11] mode, [10:8] sel, [7:0] reload
  localparam logic [11:0] VEC [8] = '{
    12'h000, 12'h003, 12'h101, 12'h200,
    12'h800, 12'h901, 12'h300, 12'h802
  };

  wdt_core dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sys_rst_o(sys_rst_o), .pd_inhibit_o(pd_inhibit_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic feed();
    wr(REG_FEED, FEED_KEY_A);
    wr(REG_FEED, FEED_KEY_B);
  endtask

  // counts cycles after the last write until the flag (or reset pulse) appears
  task automatic measure(input bit use_rst, input int limit, output int n, output bit saw_rst);
    n = 0; saw_rst = 0;
    rd_addr = REG_CTRL;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (sys_rst_o) saw_rst = 1;
      if (use_rst ? sys_rst_o : rd_data[1]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    int n, exp;
    bit saw;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    rd(REG_CTRL, rv);   check("R11 ctrl", rv, 0);
    rd(REG_RELOAD, rv); check("R11 reload", rv, 8'hFF);
    rd(REG_COUNT, rv);  check("R11 count", rv, 8'hFF);
    check("R11 outputs", {sys_rst_o, pd_inhibit_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 unused bits read zero, fields land in place
    wr(REG_CTRL, 8'hF8);
    rd(REG_CTRL, rv); check("R2 layout", rv, 8'hE0);
    wr(REG_CTRL, 8'h00);
    // R5 writing 1 to flag does not set it
    wr(REG_CTRL, 8'h02);
    rd(REG_CTRL, rv); check("R5 flag write 1", rv[1], 0);
    wr(REG_CTRL, 8'h00);

    // table of period vectors
    foreach (VEC[i]) begin
      logic m; logic [2:0] s; logic [7:0] r;
      m = VEC[i][11]; s = VEC[i][10:8]; r = VEC[i][7:0];
      exp = (int'(r) + 1) * (768 << s);
      wr(REG_RELOAD, r);
      feed();
      wr(REG_CTRL, {s, 2'b00, ~m, 1'b0, m});
      measure(m, exp + 20, n, saw);
      check("R1 period", n, exp);
      if (m) begin
        rd(REG_CTRL, rv); check("R6 flag on watchdog", rv[1], 1);
        check("R7 inhibit high", pd_inhibit_o, 1);
        @(negedge clk); check("R6 one-cycle pulse", sys_rst_o, 0);
        wr(REG_CTRL, {s, 5'b00000});
        rd(REG_CTRL, rv); check("R8 mode held", rv[0], 1);
        feed();
        rd(REG_CTRL, rv); check("R8 mode exit", rv[0], 0);
        check("R7 inhibit low", pd_inhibit_o, 0);
      end else begin
        check("R4 no reset pulse", saw, 0);
        rd(REG_COUNT, rv); check("R4 reloaded", rv, r);
        wr(REG_CTRL, 8'h00);
        rd(REG_CTRL, rv); check("R5 flag cleared", rv[1], 0);
      end
      wr(REG_CTRL, 8'h00);
    end

    // R10 control rewrite restarts prescaler; R3 run=0 freezes
    wr(REG_RELOAD, 8'd5);
    feed();
    wr(REG_CTRL, 8'h04);
    repeat (500) @(negedge clk);
    wr(REG_CTRL, 8'h04);
    n = 0; rd_addr = REG_COUNT;
    while (n < 900) begin
      @(negedge clk); n++;
      if (rd_data == 8'd4) break;
    end
    check("R10 restart", n, 768);
    wr(REG_CTRL, 8'h00);
    repeat (2000) @(negedge clk);
    rd(REG_COUNT, rv); check("R3 frozen count", rv, 4);
    rd(REG_CTRL, rv);  check("R3 no flag", rv[1], 0);

    // R9 broken feed does not release watchdog mode
    wr(REG_RELOAD, 8'd200);
    feed();
    wr(REG_CTRL, 8'h01);
    wr(REG_CTRL, 8'h00);
    wr(REG_FEED, FEED_KEY_A);
    wr(REG_RELOAD, 8'd1);
    wr(REG_FEED, FEED_KEY_B);
    rd(REG_CTRL, rv); check("R9 aborted feed", rv[0], 1);
    repeat (1000) @(negedge clk);
    feed();
    rd(REG_CTRL, rv); check("R9 good feed exits", rv[0], 0);
    rd(REG_COUNT, rv); check("R9 feed loads count", rv, 1);

    // R9 feed restarts watchdog interval
    wr(REG_RELOAD, 8'd200);
    feed();
    wr(REG_RELOAD, 8'd1);
    wr(REG_CTRL, 8'h01);
    repeat (1000) @(negedge clk);
    feed();
    measure(1, 2000, n, saw);
    check("R9 feed restart period", n, 2 * 768);

    // R11 reset in watchdog mode
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(REG_CTRL, rv); check("R11 ctrl after reset", rv, 0);
    check("R11 inhibit after reset", pd_inhibit_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule